// File: doc/BRIEF.md
# DRAM Address Latch and Multiplexer

This block captures the row, column and bank of a memory access and places the right one on the multiplexed DRAM address bus. It has two capture disciplines. In the synchronous one, a latch-enable strobe keeps the latch open while it is high, and the latch closes when the strobe drops. In the asynchronous one, the latch stays open until an address strobe arrives, captures on that strobe, and reopens once the access has ended. A bypass setting makes the latches permanently transparent.

During an access the bus carries the row address first. From the cycle in which the timing logic raises the column-select strobe, it carries the column address. With pipelining enabled, the bus returns to the row address after one cycle of column hold. With pipelining disabled, the column stays on the bus until the access ends.

A column-increment input steps the latched column through page or static-column bursts and wraps at all-ones. While a refresh is in progress, the bus carries the refresh row address. In that state the increment input does not step the column and is passed out as a refresh-extend request.

Top module: `dram_addr_mux`

## Requirements
- R1: After reset, with asynchronous mode selected, `latch_bypass` low, `access_on` low and `rfsh_busy` low, the latch is open: `dram_addr` equals `row_in` and `bank_out` equals `bank_in` in the same cycle.
- R2: With `latch_bypass`=1, `dram_addr` (in its row or column phase) and `bank_out` follow the inputs in the same cycle, and `colinc` has no effect on the column shown.
- R3: With `mode_async`=0 and `latch_bypass`=0, the outputs follow the inputs while `addr_stb` is high. While `addr_stb` is low, they hold the values sampled at the last rising clock edge at which `addr_stb` was high.
- R4: With `mode_async`=1 and `latch_bypass`=0, the latch is open until the first rising edge at which `addr_stb` is high, and it captures the inputs at that edge. Later input changes are ignored until a rising edge at which both `addr_stb` and `access_on` are low, which reopens the latch.
- R5: At each rising edge with `colinc`=1, `access_on`=1, `rfsh_busy`=0 and the latch closed, the latched column increases by one, and all-ones wraps to zero.
- R6: While `rfsh_busy`=1, `colinc` does not change the latched column and `rfsh_extend` equals `colinc`. While `rfsh_busy`=0, `rfsh_extend` is 0.
- R7: While `rfsh_busy`=1, `dram_addr` equals `rfsh_row`, whatever the access state.
- R8: During an access (`access_on`=1), `dram_addr` carries the row until `col_sel` is high. It carries the column in the first cycle in which `col_sel` is high. When `access_on` is 0, it carries the row.
- R9: With `pipe_en`=1, the column stays on the bus for the `col_sel` cycle and the one cycle after it. From the second cycle after, the row returns and stays until the access ends.
- R10: With `pipe_en`=0, the column stays on the bus from `col_sel` until `access_on` falls, and the row is shown in that same cycle.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| row_in | input | ROW_W | Row address from the requester |
| col_in | input | COL_W | Column address from the requester |
| bank_in | input | BANK_W | Bank select from the requester |
| addr_stb | input | 1 | Latch enable (synchronous mode) or address strobe (asynchronous mode), active high |
| mode_async | input | 1 | 0: latch-enable capture, 1: strobe capture |
| latch_bypass | input | 1 | 1: latches permanently transparent |
| colinc | input | 1 | Column increment; refresh-extend request during refresh |
| rfsh_busy | input | 1 | Refresh in progress |
| rfsh_row | input | ROW_W | Refresh row address |
| col_sel | input | 1 | Column-select strobe from the timing logic |
| access_on | input | 1 | Access row strobe active |
| pipe_en | input | 1 | 1: return to row after column hold |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed DRAM address |
| bank_out | output | BANK_W | Latched bank select |
| rfsh_extend | output | 1 | Refresh-extend request |

## Verification
The capture function is tried with the strobe held high while the inputs change, and then with the inputs changing after the strobe drops. This separates transparency from holding in both capture modes, and bypass shows that neither discipline applies when it is set. The asynchronous pattern reopens the latch only at an idle edge, which separates a correct reopen from one that is early or missing. Column stepping starts one below all-ones, so the increment and the wrap are seen in two consecutive edges, and a refresh in the middle of the burst shows that the column is frozen and the extend request is passed out. The output sequencing is run with pipelining on and off under the same `col_sel` pattern, so the one-cycle hold and the held column can be told apart.

// File: rtl/dram_addr_pkg.sv
package dram_addr_pkg;
   typedef enum logic [1:0] {
      PH_ROW  = 2'd0,
      PH_HOLD = 2'd1,
      PH_BACK = 2'd2
   } phase_e;
endpackage

// File: rtl/dam_latch_ctrl.sv
module dam_latch_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic mode_async,
   input  logic bypass,
   input  logic access_on,
   output logic open_now
);
   logic closed_q;

   assign open_now = bypass | (~mode_async & strobe) | (mode_async & ~closed_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         closed_q <= 1'b0;
      else if (!mode_async)
         closed_q <= 1'b0;
      else if (strobe)
         closed_q <= 1'b1;
      else if (!access_on)
         closed_q <= 1'b0;
   end

   // R4: a strobe in asynchronous mode closes the latch
   a_r4_strobe_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_async && strobe) |=> closed_q);
   // R4: the latch reopens only at an idle edge
   a_r4_idle_reopens: assert property (@(posedge clk) disable iff (!rst_n)
      (closed_q && mode_async && (strobe || access_on)) |=> closed_q);
endmodule

// File: rtl/dam_hold_reg.sv
module dam_hold_reg #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         open_now,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held_q <= '0;
      else if (open_now)
         held_q <= d;
   end

   assign q = open_now ? d : held_q;

   // R3: a closed latch keeps its stored value
   a_r3_closed_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !open_now |=> $stable(held_q));
endmodule

// File: rtl/dam_col_ctr.sv
module dam_col_ctr #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         open_now,
   input  logic         inc,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] col_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         col_q <= '0;
      else if (open_now)
         col_q <= d;
      else if (inc)
         col_q <= col_q + 1'b1;
   end

   assign q = open_now ? d : col_q;

   // R5: all-ones steps to zero
   a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !open_now && col_q == '1) |=> (col_q == '0));
   // R6: no step without an increment
   a_r6_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !open_now) |=> $stable(col_q));
endmodule

// File: rtl/dam_out_mux.sv
module dam_out_mux
   import dram_addr_pkg::*;
#(
   parameter int ROW_W = 11,
   parameter int COL_W = 11,
   parameter int AW    = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             access_on,
   input  logic             col_sel,
   input  logic             pipe_en,
   input  logic             rfsh_busy,
   input  logic [ROW_W-1:0] row,
   input  logic [COL_W-1:0] col,
   input  logic [ROW_W-1:0] rfsh_row,
   output logic [AW-1:0]    addr
);
   phase_e ph_q, ph_d;
   logic [AW-1:0] row_x, col_x, ref_x;

   assign row_x = AW'(row);
   assign col_x = AW'(col);
   assign ref_x = AW'(rfsh_row);

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_ROW:  if (access_on && col_sel) ph_d = PH_HOLD;
         PH_HOLD: if (!access_on) ph_d = PH_ROW;
                  else if (pipe_en) ph_d = PH_BACK;
         PH_BACK: if (!access_on) ph_d = PH_ROW;
         default: ph_d = PH_ROW;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_ROW;
      else        ph_q <= ph_d;
   end

   always_comb begin
      if (rfsh_busy)
         addr = ref_x;
      else if (!access_on)
         addr = row_x;
      else begin
         unique case (ph_q)
            PH_ROW:  addr = col_sel ? col_x : row_x;
            PH_HOLD: addr = col_x;
            default: addr = row_x;
         endcase
      end
   end

   // R9: one cycle of column hold, then back to row
   a_r9_return_row: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_HOLD && access_on && pipe_en) |=> (ph_q == PH_BACK));
   // R10: column held while the access lasts
   a_r10_hold_col: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_HOLD && access_on && !pipe_en) |=> (ph_q == PH_HOLD));
   // R7: refresh row on the bus
   a_r7_refresh_addr: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_busy |-> (addr == ref_x));
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
   parameter int ROW_W  = 11,
   parameter int COL_W  = 11,
   parameter int BANK_W = 2,
   localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ROW_W-1:0]  row_in,
   input  logic [COL_W-1:0]  col_in,
   input  logic [BANK_W-1:0] bank_in,
   input  logic              addr_stb,
   input  logic              mode_async,
   input  logic              latch_bypass,
   input  logic              colinc,
   input  logic              rfsh_busy,
   input  logic [ROW_W-1:0]  rfsh_row,
   input  logic              col_sel,
   input  logic              access_on,
   input  logic              pipe_en,
   output logic [AW-1:0]     dram_addr,
   output logic [BANK_W-1:0] bank_out,
   output logic              rfsh_extend
);
   if (ROW_W < 2 || COL_W < 2 || BANK_W < 1) begin : g_bad_width
      initial $error("dram_addr_mux: address widths out of range");
   end

   logic             open_now;
   logic             col_step;
   logic [ROW_W-1:0] row_l;
   logic [COL_W-1:0] col_l;

   dam_latch_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe     (addr_stb),
      .mode_async (mode_async),
      .bypass     (latch_bypass),
      .access_on  (access_on),
      .open_now   (open_now)
   );

   dam_hold_reg #(.W(ROW_W)) u_row (
      .clk(clk), .rst_n(rst_n), .open_now(open_now), .d(row_in), .q(row_l));

   dam_hold_reg #(.W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .open_now(open_now), .d(bank_in), .q(bank_out));

   assign col_step = colinc & ~rfsh_busy & access_on;

   dam_col_ctr #(.W(COL_W)) u_col (
      .clk(clk), .rst_n(rst_n), .open_now(open_now), .inc(col_step),
      .d(col_in), .q(col_l));

   dam_out_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .AW(AW)) u_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .access_on (access_on),
      .col_sel   (col_sel),
      .pipe_en   (pipe_en),
      .rfsh_busy (rfsh_busy),
      .row       (row_l),
      .col       (col_l),
      .rfsh_row  (rfsh_row),
      .addr      (dram_addr)
   );

   assign rfsh_extend = colinc & rfsh_busy;

   // R6: no extend request outside refresh
   a_r6_extend_only_refresh: assert property (@(posedge clk) disable iff (!rst_n)
      !rfsh_busy |-> !rfsh_extend);
   // R2: bypass passes the bank through
   a_r2_bypass_bank: assert property (@(posedge clk) disable iff (!rst_n)
      latch_bypass |-> (bank_out == bank_in));
endmodule

// File: tb/dram_addr_mux_tb.sv
module dram_addr_mux_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] row_in = '0, col_in = '0, rfsh_row = '0;
   logic [1:0]  bank_in = '0;
   logic addr_stb = 0, mode_async = 1, latch_bypass = 0, colinc = 0;
   logic rfsh_busy = 0, col_sel = 0, access_on = 0, pipe_en = 0;
   logic [10:0] dram_addr;
   logic [1:0]  bank_out;
   logic        rfsh_extend;
   int total = 0, bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_addr_mux u_dut (.*);

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic t_reset();
      settle();
      row_in = 11'h2A5; bank_in = 2'd3; settle();
      chk("R1 reset addr", dram_addr, 11'h2A5);
      chk("R1 reset bank", bank_out, 3);
   endtask

   task automatic t_bypass();
      latch_bypass = 1; access_on = 1; col_sel = 1;
      col_in = 11'h055; bank_in = 2'd2; settle();
      chk("R2 bypass col", dram_addr, 11'h055);
      colinc = 1; tick(); colinc = 0; settle();
      chk("R2 colinc ignored", dram_addr, 11'h055);
      col_in = 11'h066; bank_in = 2'd1; settle();
      chk("R2 follow col", dram_addr, 11'h066);
      chk("R2 follow bank", bank_out, 1);
      access_on = 0; col_sel = 0; latch_bypass = 0; tick();
   endtask

   task automatic t_sync();
      mode_async = 0; addr_stb = 1; row_in = 11'h0AA; bank_in = 2'd1; settle();
      chk("R3 transparent", dram_addr, 11'h0AA);
      row_in = 11'h0AB; settle();
      chk("R3 transparent change", dram_addr, 11'h0AB);
      tick();
      addr_stb = 0; row_in = 11'h3FF; bank_in = 2'd2; settle();
      chk("R3 held row", dram_addr, 11'h0AB);
      chk("R3 held bank", bank_out, 1);
      tick();
      chk("R3 still held", dram_addr, 11'h0AB);
      mode_async = 1; tick();
   endtask

   task automatic t_async();
      addr_stb = 0; access_on = 0; tick();
      addr_stb = 1; access_on = 1; row_in = 11'h101; bank_in = 2'd0; tick();
      addr_stb = 0; row_in = 11'h202; bank_in = 2'd3; settle();
      chk("R4 captured row", dram_addr, 11'h101);
      chk("R4 captured bank", bank_out, 0);
      tick();
      chk("R4 stays closed", dram_addr, 11'h101);
      access_on = 0; settle();
      chk("R4 closed until edge", dram_addr, 11'h101);
      tick();
      chk("R4 reopened", dram_addr, 11'h202);
   endtask

   task automatic t_colinc_refresh();
      pipe_en = 0; addr_stb = 0; access_on = 0; tick();
      row_in = 11'h0C3; col_in = 11'h7FE; addr_stb = 1; access_on = 1; tick();
      addr_stb = 0; col_in = 11'h011; row_in = 11'h000; settle();
      chk("R8 row before col_sel", dram_addr, 11'h0C3);
      col_sel = 1; settle();
      chk("R8 col at col_sel", dram_addr, 11'h7FE);
      colinc = 1; tick();
      chk("R5 increment", dram_addr, 11'h7FF);
      tick();
      chk("R5 wrap", dram_addr, 11'h000);
      rfsh_busy = 1; rfsh_row = 11'h155; settle();
      chk("R7 refresh addr", dram_addr, 11'h155);
      chk("R6 extend on", rfsh_extend, 1);
      tick();
      rfsh_busy = 0; colinc = 0; settle();
      chk("R6 no step in refresh", dram_addr, 11'h000);
      chk("R6 extend off", rfsh_extend, 0);
      colinc = 1; settle();
      chk("R6 extend off busy low", rfsh_extend, 0);
      colinc = 0;
      tick(); tick();
      chk("R10 col held", dram_addr, 11'h000);
      access_on = 0; col_sel = 0; settle();
      chk("R10 row at end", dram_addr, 11'h0C3);
      tick();
   endtask

   task automatic t_pipe();
      pipe_en = 1; addr_stb = 0; access_on = 0; tick();
      row_in = 11'h0F0; col_in = 11'h00F; addr_stb = 1; access_on = 1; tick();
      addr_stb = 0; settle();
      chk("R8 pipe row first", dram_addr, 11'h0F0);
      col_sel = 1; settle();
      chk("R9 col strobe cycle", dram_addr, 11'h00F);
      tick();
      chk("R9 col hold cycle", dram_addr, 11'h00F);
      tick();
      chk("R9 back to row", dram_addr, 11'h0F0);
      tick();
      chk("R9 row kept", dram_addr, 11'h0F0);
      access_on = 0; col_sel = 0; pipe_en = 0; tick();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      tick();
      t_reset();
      t_bypass();
      t_sync();
      t_async();
      t_colinc_refresh();
      t_pipe();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule